// File: doc/BRIEF.md
# Two-Wire Register Bank Slave

This block is a serial slave on a two-wire bus (clock and data, both open-drain) that gives a host controller access to a bank of eight 8-bit control registers. The bus lines are oversampled by a fast system clock through synchronizers. START and STOP conditions are found as data-line edges while the bus clock is high. The slave pulls the data line low through a single drive-low enable, and the board supplies the pull-up.

A transfer begins with the address byte. The first byte after a write address is a command. When its top bit is set, the command selects single-byte mode, and its low seven bits hold the register offset. When its top bit is clear, the command selects block mode, which always starts at register 0. In block mode a write carries a byte count and then data in ascending register order. A block read, after a repeated START with the read address, returns the count first and then the registers. Register contents are visible in parallel at `regs_o`. Some bits are read-only, and every register reloads its default on reset.

Top module: `smb_regbank_slave`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x69 (byte 0xD2 to write, 0xD3 to read). Any other address gets no acknowledge, and the slave ignores the bus until the next START.
- R2: A command byte with bit 7 = 1 selects single-byte mode at offset bits 6:0. One following data byte is acknowledged and written. A second data byte is not acknowledged and is discarded.
- R3: A single-byte command whose offset is above 7 is not acknowledged, and the slave releases the bus until the next START.
- R4: A single-byte read (command, repeated START, read address) returns exactly the addressed register, MSB first. After that byte the slave keeps SDA released, so the master reads 0xFF even if it acknowledges.
- R5: A command byte with bit 7 = 0 selects block mode starting at register 0, whatever bits 6:0 hold. The next byte is a count. Data bytes are acknowledged and written to registers 0, 1, 2 and so on only while the count is not used up and the register index is at most 7. Any other byte is not acknowledged and is discarded.
- R6: A block read returns the count byte 8, then registers 0 to 7 in order. It continues while the master acknowledges, and bytes past register 7 read 0xFF.
- R7: Read-only bits keep their value on any write: all of register 7 (an identification value 0x48) and bits 1:0 of register 0.
- R8: After reset the registers 0 to 7 hold 0x0D, 0xA7, 0x00, 0xFF, 0x47, 0xDF, 0x03 and 0x48, and SDA is released.
- R9: A STOP after any complete byte ends the transfer and releases SDA. The bytes acknowledged before it stay written, and the next transfer works normally.
- R10: The slave changes its SDA drive only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| regs_o | output | 64 | Register bank, register n at bits 8n+7:8n |

## Verification
The bench targets the points where a slave most often goes wrong:
- A foreign address must be ignored. A slave that still decoded the following bytes would corrupt registers.
- A second data byte in single-byte mode must be discarded. A slave that auto-incremented here would write the next register.
- An out-of-range offset must be refused. Without that check, a write to a nonexistent register would alias onto a real one.
- Block writes that run past the count or past the last register must be refused. A slave that got this wrong would overwrite data.
- On reads, the bench checks that the count byte comes first, that single-byte reads stop after one byte, and that the line stays still while SCL is high. A misplaced drive change would show up as a false START or STOP.

// File: rtl/smb_regbank_slave.sv
module smb_regbank_slave #(
  parameter int NUM_REGS = 8,
  parameter logic [6:0] SLAVE_ADDR = 7'h69,
  parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'h48_03_DF_47_FF_00_A7_0D,
  parameter logic [NUM_REGS*8-1:0] REG_RO_MASK  = 64'hFF_00_00_00_00_00_00_03,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] regs_o
);
  localparam int IW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam logic [6:0] LAST = 7'(NUM_REGS - 1);
  localparam logic [7:0] CNT_BYTE = 8'(NUM_REGS);

  typedef enum logic [2:0] {S_IDLE, S_RX, S_RX_ACK, S_TX, S_TX_ACK, S_WAIT} state_t;
  typedef enum logic [1:0] {B_ADDR, B_CMD, B_CNT, B_DATA} role_t;

  logic [SYNC_STAGES-1:0] scl_sync, sda_sync;
  logic scl_q, sda_q;
  logic scl_s, sda_s;
  assign scl_s = scl_sync[SYNC_STAGES-1];
  assign sda_s = sda_sync[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sync <= '1; sda_sync <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_i};
      sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_i};
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  wire scl_rise  = scl_s & ~scl_q;
  wire scl_fall  = ~scl_s & scl_q;
  wire start_evt = scl_s & scl_q & sda_q & ~sda_s;
  wire stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

  state_t state;
  role_t role;
  logic [3:0] bcnt;
  logic [7:0] sh, tx, rem;
  logic [6:0] ptr;
  logic blk, rd, send_cnt, mack, oe;
  logic [7:0] reg_q [NUM_REGS];

  wire in_range = ptr <= LAST;
  wire addr_hit = sh[7:1] == SLAVE_ADDR;
  wire byte_done = (state == S_RX) && scl_fall && (bcnt == 4'd8);
  wire [7:0] rd_data = in_range ? reg_q[ptr[IW-1:0]] : 8'hFF;
  wire [7:0] next_tx = (blk && send_cnt) ? CNT_BYTE : rd_data;
  wire ld_tx = scl_fall && ((state == S_RX_ACK && rd) || (state == S_TX_ACK && !mack && blk));

  assign sda_oe_o = oe;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
    assign regs_o[g*8 +: 8] = reg_q[g];
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; role <= B_ADDR; bcnt <= '0; sh <= '0; tx <= '0;
      rem <= '0; ptr <= '0; blk <= 1'b0; rd <= 1'b0; send_cnt <= 1'b0;
      mack <= 1'b1; oe <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) reg_q[i] <= REG_DEFAULTS[i*8 +: 8];
    end else if (start_evt) begin
      state <= S_RX; role <= B_ADDR; bcnt <= '0; oe <= 1'b0;
    end else if (stop_evt) begin
      state <= S_IDLE; oe <= 1'b0;
    end else begin
      case (state)
        S_RX:
          if (scl_rise && bcnt != 4'd8) begin
            sh <= {sh[6:0], sda_s};
            bcnt <= bcnt + 4'd1;
          end else if (byte_done) begin
            bcnt <= '0;
            state <= S_RX_ACK;
            oe <= 1'b1;
            case (role)
              B_ADDR:
                if (!addr_hit) begin
                  state <= S_WAIT; oe <= 1'b0;
                end else begin
                  rd <= sh[0];
                  send_cnt <= sh[0] & blk;
                  role <= B_CMD;
                end
              B_CMD:
                if (sh[7]) begin
                  if (sh[6:0] <= LAST) begin
                    blk <= 1'b0; ptr <= sh[6:0]; rem <= 8'd1; role <= B_DATA;
                  end else begin
                    state <= S_WAIT; oe <= 1'b0;
                  end
                end else begin
                  blk <= 1'b1; ptr <= '0; role <= B_CNT;
                end
              B_CNT: begin
                rem <= sh; role <= B_DATA;
              end
              default:
                if (rem != 8'd0 && in_range) begin
                  reg_q[ptr[IW-1:0]] <= (sh & ~REG_RO_MASK[ptr[IW-1:0]*8 +: 8]) |
                                        (reg_q[ptr[IW-1:0]] & REG_RO_MASK[ptr[IW-1:0]*8 +: 8]);
                  ptr <= ptr + 7'd1;
                  rem <= rem - 8'd1;
                end else begin
                  state <= S_WAIT; oe <= 1'b0;
                end
            endcase
          end
        S_RX_ACK:
          if (scl_fall) begin
            oe <= 1'b0;
            state <= S_RX;
          end
        S_TX:
          if (scl_rise) bcnt <= bcnt + 4'd1;
          else if (scl_fall) begin
            if (bcnt == 4'd8) begin
              oe <= 1'b0; state <= S_TX_ACK;
            end else begin
              tx <= {tx[6:0], 1'b0};
              oe <= ~tx[6];
            end
          end
        S_TX_ACK:
          if (scl_rise) mack <= sda_s;
          else if (scl_fall) state <= S_WAIT;
        default: ;
      endcase
      if (ld_tx) begin
        state <= S_TX;
        bcnt <= '0;
        tx <= next_tx;
        oe <= ~next_tx[7];
        if (blk && send_cnt) send_cnt <= 1'b0;
        else if (in_range) ptr <= ptr + 7'd1;
      end
    end

  a_r1_foreign_addr_released: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && role == B_ADDR && !addr_hit && !start_evt && !stop_evt) |=> !sda_oe_o);

  a_r3_offset_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && role == B_CMD && sh[7] && sh[6:0] > LAST && !start_evt && !stop_evt)
      |=> (!sda_oe_o && state == S_WAIT));

  a_r5_bit_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    bcnt <= 4'd8);

  a_r7_readonly_hold: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(regs_o & REG_RO_MASK));

  a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe_o);

  a_r10_drive_change_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe_o) |-> !scl_s);
endmodule

// File: tb/test_smb_regbank_slave.sv
module test_smb_regbank_slave;
  localparam int QTR = 10;
  localparam logic [63:0] DEFS = 64'h48_03_DF_47_FF_00_A7_0D;
  localparam logic [63:0] ROM  = 64'hFF_00_00_00_00_00_00_03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe;
  logic [63:0] regs;
  wire sda_line = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_regbank_slave i_smb_regbank_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .regs_o(regs)
  );

  int tests = 0, fails = 0, glitch = 0;
  bit done = 1'b0;
  logic [63:0] exp_regs = DEFS;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic model_wr(input int idx, input logic [7:0] v);
    exp_regs[idx*8 +: 8] = (v & ~ROM[idx*8 +: 8]) | (exp_regs[idx*8 +: 8] & ROM[idx*8 +: 8]);
  endtask

  task automatic q(); repeat (QTR) @(negedge clk); endtask
  task automatic bus_start(); sda_m = 1; q(); scl_m = 1; q(); sda_m = 0; q(); scl_m = 0; q(); endtask
  task automatic bus_stop(); sda_m = 0; q(); scl_m = 1; q(); sda_m = 1; q(); q(); endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; q(); scl_m = 1; q(); q(); scl_m = 0; q();
    end
    sda_m = 1; q(); scl_m = 1; q(); ack = !sda_line; q(); scl_m = 0; q();
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] d);
    sda_m = 1;
    for (int i = 7; i >= 0; i--) begin
      q(); scl_m = 1; q(); d[i] = sda_line; q();
      if (sda_line !== d[i]) glitch++;
      scl_m = 0;
    end
    q(); sda_m = give_ack ? 1'b0 : 1'b1; q(); scl_m = 1; q(); q(); scl_m = 0; q(); sda_m = 1;
  endtask

  task automatic t_reset();
    chk(regs === DEFS, "R8 reset values", regs, DEFS);
    chk(sda_oe === 1'b0, "R8 sda released", {63'd0, sda_oe}, 64'd0);
  endtask

  task automatic t_byte_write();
    bit a0, a1, a2, a3;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h83, a1); wr_byte(8'h5A, a2); wr_byte(8'h66, a3); bus_stop();
    model_wr(3, 8'h5A);
    chk(a0 && a1 && a2, "R2 acks", {61'd0, a0, a1, a2}, 64'd7);
    chk(!a3, "R2 second byte refused", {63'd0, a3}, 64'd0);
    chk(regs === exp_regs, "R2 single register written", regs, exp_regs);
  endtask

  task automatic t_readonly();
    bit a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h87, a1); wr_byte(8'h00, a2); bus_stop();
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h80, a1); wr_byte(8'hF0, a2); bus_stop();
    model_wr(7, 8'h00); model_wr(0, 8'hF0);
    chk(regs[63:56] === 8'h48, "R7 id register kept", {56'd0, regs[63:56]}, 64'h48);
    chk(regs[7:0] === 8'hF1, "R7 reg0 low bits kept", {56'd0, regs[7:0]}, 64'hF1);
  endtask

  task automatic t_bad_addr();
    bit a0, a1, a2;
    bus_start(); wr_byte(8'hA4, a0); wr_byte(8'h81, a1); wr_byte(8'h00, a2); bus_stop();
    chk(!a0 && !a1 && !a2, "R1 foreign address ignored", {61'd0, a0, a1, a2}, 64'd0);
    chk(regs === exp_regs, "R1 registers untouched", regs, exp_regs);
  endtask

  task automatic t_bad_offset();
    bit a0, a1, a2;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h88, a1); wr_byte(8'h12, a2); bus_stop();
    chk(a0 && !a1 && !a2, "R3 offset 8 refused", {61'd0, a0, a1, a2}, 64'd4);
    chk(regs === exp_regs, "R3 registers untouched", regs, exp_regs);
  endtask

  task automatic t_byte_read();
    bit a0, a1, a2;
    logic [7:0] d0, d1;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h84, a1);
    bus_start(); wr_byte(8'hD3, a2); rd_byte(1'b1, d0); rd_byte(1'b0, d1); bus_stop();
    chk(a0 && a1 && a2, "R1 read address acked", {61'd0, a0, a1, a2}, 64'd7);
    chk(d0 === exp_regs[39:32], "R4 byte read value", {56'd0, d0}, {56'd0, exp_regs[39:32]});
    chk(d1 === 8'hFF, "R4 only one byte returned", {56'd0, d1}, 64'hFF);
  endtask

  task automatic t_block_write();
    bit a0, a1, a2, a3, a4, a5, a6;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h05, a1); wr_byte(8'h03, a2);
    wr_byte(8'h11, a3); wr_byte(8'h22, a4); wr_byte(8'h33, a5); wr_byte(8'h44, a6); bus_stop();
    model_wr(0, 8'h11); model_wr(1, 8'h22); model_wr(2, 8'h33);
    chk(a0 && a1 && a2 && a3 && a4 && a5, "R5 block acks", {58'd0, a0, a1, a2, a3, a4, a5}, 64'h3F);
    chk(!a6, "R5 byte past count refused", {63'd0, a6}, 64'd0);
    chk(regs === exp_regs, "R5 block data placed from offset 0", regs, exp_regs);
  endtask

  task automatic t_block_write_full();
    bit a, all_ok, last;
    all_ok = 1'b1;
    bus_start(); wr_byte(8'hD2, a); all_ok &= a; wr_byte(8'h00, a); all_ok &= a; wr_byte(8'h0A, a); all_ok &= a;
    for (int i = 0; i < 8; i++) begin
      wr_byte(8'hA0 + 8'(i), a); all_ok &= a; model_wr(i, 8'hA0 + 8'(i));
    end
    wr_byte(8'hEE, last); bus_stop();
    chk(all_ok, "R5 eight bytes acked", {63'd0, all_ok}, 64'd1);
    chk(!last, "R5 byte past last register refused", {63'd0, last}, 64'd0);
    chk(regs === exp_regs, "R5 full bank written", regs, exp_regs);
  endtask

  task automatic t_block_read();
    bit a0, a1, a2;
    logic [7:0] d;
    glitch = 0;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1);
    bus_start(); wr_byte(8'hD3, a2);
    rd_byte(1'b1, d);
    chk(a0 && a1 && a2 && d === 8'd8, "R6 count byte first", {56'd0, d}, 64'd8);
    for (int i = 0; i < 8; i++) begin
      rd_byte(1'b1, d);
      chk(d === exp_regs[i*8 +: 8], "R6 block read data", {56'd0, d}, {56'd0, exp_regs[i*8 +: 8]});
    end
    rd_byte(1'b0, d); bus_stop();
    chk(d === 8'hFF, "R6 past last register", {56'd0, d}, 64'hFF);
    chk(glitch == 0, "R10 sda steady while scl high", 64'(glitch), 64'd0);
  endtask

  task automatic t_early_stop();
    bit a0, a1, a2, a3, a4;
    logic [7:0] d;
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h00, a1); wr_byte(8'h04, a2);
    wr_byte(8'h5C, a3); wr_byte(8'h6D, a4); bus_stop();
    model_wr(0, 8'h5C); model_wr(1, 8'h6D);
    chk(sda_oe === 1'b0, "R9 released after stop", {63'd0, sda_oe}, 64'd0);
    chk(regs === exp_regs, "R9 partial block kept", regs, exp_regs);
    bus_start(); wr_byte(8'hD2, a0); wr_byte(8'h81, a1);
    bus_start(); wr_byte(8'hD3, a2); rd_byte(1'b0, d); bus_stop();
    chk(d === exp_regs[15:8], "R9 next transfer works", {56'd0, d}, {56'd0, exp_regs[15:8]});
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_byte_write();
    t_readonly();
    t_bad_addr();
    t_bad_offset();
    t_byte_read();
    t_block_write();
    t_block_write_full();
    t_block_read();
    t_early_stop();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule